// File: doc/BRIEF.md
# Shift Register Start-Delay Controller

This block governs the serial shift register of a peripheral adapter: an 8-bit register that moves data out to, or in from, a single serial data pin under a shift clock that the block produces. A 3-bit mode code selects where the clock comes from and which way data moves. The shift clock either follows the system clock or is paced by the low byte of the second timer's latch. When the CPU reads or writes the shift register, the block loads a start-delay counter. When the counter runs out, the shift clock makes its first falling edge and eight bits are transferred. A completion flag is then raised and the clock stops.

One time unit is one rising edge of `clk`. The system clock half-cycle is one `clk` period, so the delays are counted in `clk` edges from the edge that samples the access strobe, which is the start of the bus access. The delay depends on the kind of access. A read in a system-clock mode waits longer than a write. In the timer-paced modes the delay follows the latch value. Any qualifying access reloads the delay, even one made while an earlier start is still pending or a transfer is in progress. There is no protection against retriggering.

Top module: `sr_start_ctl`

## Requirements
- R1: After reset, `sclk_o` is 1, `sdout_o` is 1, `done_o` is 0 and `rdata_o` is 0.
- R2: In system-clock modes (`mode_i` 3'b010 shift-in, 3'b110 shift-out), a read strobe sampled at edge E makes `sclk_o` fall first at edge E+7.
- R3: In system-clock modes, a write strobe sampled at edge E makes `sclk_o` fall first at edge E+6, and the write loads `wdata_i` into the shift register.
- R4: In timer-paced modes (3'b001 shift-in, 3'b101 shift-out), a read or a write at edge E makes `sclk_o` fall first at edge E+`t2_lo_i`+2.
- R5: In the free-running shift-out mode (3'b100), a write at edge E makes `sclk_o` fall first at edge E+`t2_lo_i`+2. A read arms nothing, and `sclk_o` stays 1.
- R6: A qualifying access made while a start is pending discards the pending start. The first falling edge is then timed from the later access alone.
- R7: Each half-period of `sclk_o` lasts 1 edge in system-clock modes and `t2_lo_i`+2 edges in the timer-paced and free-running modes. The eighth rising edge comes 15 half-periods after the first falling edge.
- R8: In shift-out modes, `sdout_o` changes on each falling edge of `sclk_o` and is stable through the next rising edge. The bits come most significant first, and the register rotates, so after 8 bits `rdata_o` holds its value from before the transfer.
- R9: In shift-in modes, `sdin_i` is sampled at each rising edge of `sclk_o` into bit 0 while the register shifts toward bit 7. After 8 bits, the first bit sampled is in bit 7.
- R10: On the eighth rising edge, `done_o` goes to 1 and `sclk_o` stays 1. Any read or write clears `done_o` at the edge that samples it.
- R11: With `mode_i` at 3'b000 or at a reserved code (3'b011, 3'b111), accesses arm nothing, `sclk_o` is held at 1, and a pending start is cancelled. A write still loads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per system half-cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Shift mode code |
| t2_lo_i | input | T2_W | Low byte of timer-2 latch |
| rd_i | input | 1 | One-cycle strobe, start of a shift-register read |
| wr_i | input | 1 | One-cycle strobe, start of a shift-register write |
| wdata_i | input | DATA_W | Write data |
| sdin_i | input | 1 | Serial data input |
| sclk_o | output | 1 | Shift clock |
| sdout_o | output | 1 | Serial data output |
| rdata_o | output | DATA_W | Shift register contents |
| done_o | output | 1 | Shift-complete flag |

## Verification
The assertions assume that each access strobe lasts a single cycle. They also assume that `mode_i` and `t2_lo_i` do not change between an access and the end of the transfer it starts. The only exception is a change to a disabled code, which must cancel the transfer. The bench changes mode and latch only while the block is idle, or in the one test that cancels a pending start. It gives every strobe exactly one clock period, driven on the falling clock edge. The serial input is updated on the bench side after each observed falling edge of the shift clock, so it is stable at the rising edge that samples it.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam logic [2:0] MODE_OFF      = 3'b000;
   localparam logic [2:0] MODE_IN_T2    = 3'b001;
   localparam logic [2:0] MODE_IN_SYS   = 3'b010;
   localparam logic [2:0] MODE_OUT_FREE = 3'b100;
   localparam logic [2:0] MODE_OUT_T2   = 3'b101;
   localparam logic [2:0] MODE_OUT_SYS  = 3'b110;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_T2   = 2'd2
   } clk_src_e;

   typedef struct packed {
      clk_src_e src;
      logic     shift_out;
      logic     rd_arms;
   } mode_info_t;

   function automatic mode_info_t decode_mode(input logic [2:0] m);
      mode_info_t r;
      r = '{src: SRC_NONE, shift_out: 1'b0, rd_arms: 1'b0};
      case (m)
         MODE_IN_T2:    r = '{src: SRC_T2,  shift_out: 1'b0, rd_arms: 1'b1};
         MODE_IN_SYS:   r = '{src: SRC_SYS, shift_out: 1'b0, rd_arms: 1'b1};
         MODE_OUT_FREE: r = '{src: SRC_T2,  shift_out: 1'b1, rd_arms: 1'b0};
         MODE_OUT_T2:   r = '{src: SRC_T2,  shift_out: 1'b1, rd_arms: 1'b1};
         MODE_OUT_SYS:  r = '{src: SRC_SYS, shift_out: 1'b1, rd_arms: 1'b1};
         default:       r = '{src: SRC_NONE, shift_out: 1'b0, rd_arms: 1'b0};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/sr_mode_decode.sv
module sr_mode_decode
   import sr_pkg::*;
#(
   parameter int T2_W     = 8,
   parameter int CNT_W    = 10,
   parameter int RD_DLY   = 7,
   parameter int WR_DLY   = 6,
   parameter int T2_EXTRA = 2
) (
   input  logic [2:0]       mode_i,
   input  logic [T2_W-1:0]  t2_lo_i,
   input  logic             rd_i,
   input  logic             wr_i,
   output logic             arm_o,
   output logic             active_o,
   output logic             shift_out_o,
   output logic [CNT_W-1:0] load_o,
   output logic [CNT_W-1:0] half_o
);
   mode_info_t       info;
   logic [CNT_W-1:0] t2_span;

   always_comb begin
      info        = decode_mode(mode_i);
      t2_span     = CNT_W'(t2_lo_i) + CNT_W'(T2_EXTRA);
      active_o    = (info.src != SRC_NONE);
      shift_out_o = info.shift_out;
      arm_o       = active_o && (wr_i || (rd_i && info.rd_arms));
      if (info.src == SRC_SYS) begin
         load_o = wr_i ? CNT_W'(WR_DLY) : CNT_W'(RD_DLY);
         half_o = CNT_W'(1);
      end else begin
         load_o = t2_span;
         half_o = t2_span;
      end
   end
endmodule

// File: rtl/sr_start_delay.sv
module sr_start_delay #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             abort_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             fire_o,
   output logic             pending_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (arm_i) begin
         pend_q <= 1'b1;
         cnt_q  <= load_i - CNT_W'(1);
      end else if (abort_i) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (cnt_q == '0) pend_q <= 1'b0;
         else             cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign fire_o    = pend_q && (cnt_q == '0) && !arm_i && !abort_i;
   assign pending_o = pend_q;

   // every load is at least 2, so a fresh arm never fires on the next edge
   assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (pend_q && !fire_o));
   assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && !arm_i) |=> !pend_q);
endmodule

// File: rtl/sr_shift_engine.sv
module sr_shift_engine #(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 10,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic              restart_i,
   input  logic              abort_i,
   input  logic [CNT_W-1:0]  half_i,
   input  logic              shift_out_i,
   input  logic              sdin_i,
   input  logic              wr_load_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              acc_i,
   output logic              sclk_o,
   output logic              sdout_o,
   output logic [DATA_W-1:0] sr_o,
   output logic              done_o
);
   localparam int BC_W = $clog2(DATA_W + 1);

   logic              running_q, sclk_q, sdout_q, done_q;
   logic [CNT_W-1:0]  phase_q;
   logic [BC_W-1:0]   bits_q;
   logic [DATA_W-1:0] sr_q, sr_rot, sr_in;
   logic              out_bit, last_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit = sr_q[DATA_W-1];
         assign sr_rot  = {sr_q[DATA_W-2:0], sr_q[DATA_W-1]};
         assign sr_in   = {sr_q[DATA_W-2:0], sdin_i};
      end else begin : g_lsb
         assign out_bit = sr_q[0];
         assign sr_rot  = {sr_q[0], sr_q[DATA_W-1:1]};
         assign sr_in   = {sdin_i, sr_q[DATA_W-1:1]};
      end
   endgenerate

   assign last_bit = (bits_q == BC_W'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         sclk_q    <= 1'b1;
         sdout_q   <= 1'b1;
         done_q    <= 1'b0;
         phase_q   <= '0;
         bits_q    <= '0;
         sr_q      <= '0;
      end else begin
         if (restart_i || abort_i) begin
            running_q <= 1'b0;
            sclk_q    <= 1'b1;
            bits_q    <= '0;
            phase_q   <= '0;
         end else if (fire_i) begin
            running_q <= 1'b1;
            sclk_q    <= 1'b0;
            bits_q    <= '0;
            phase_q   <= half_i - CNT_W'(1);
            if (shift_out_i) begin
               sdout_q <= out_bit;
               sr_q    <= sr_rot;
            end
         end else if (running_q) begin
            if (phase_q != '0) begin
               phase_q <= phase_q - CNT_W'(1);
            end else if (sclk_q) begin
               sclk_q  <= 1'b0;
               phase_q <= half_i - CNT_W'(1);
               if (shift_out_i) begin
                  sdout_q <= out_bit;
                  sr_q    <= sr_rot;
               end
            end else begin
               sclk_q  <= 1'b1;
               phase_q <= half_i - CNT_W'(1);
               if (!shift_out_i) sr_q <= sr_in;
               if (last_bit) begin
                  running_q <= 1'b0;
                  done_q    <= 1'b1;
               end else begin
                  bits_q <= bits_q + BC_W'(1);
               end
            end
         end
         if (wr_load_i) sr_q   <= wr_data_i;
         if (acc_i)     done_q <= 1'b0;
      end
   end

   assign sclk_o  = sclk_q;
   assign sdout_o = sdout_q;
   assign sr_o    = sr_q;
   assign done_o  = done_q;

   assert_first_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !sclk_q);
   assert_done_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> sclk_q);
   assert_bit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      running_q |-> (bits_q < BC_W'(DATA_W)));
   assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && $rose(sclk_q)) |-> $stable(sdout_q));
endmodule

// File: rtl/sr_start_ctl.sv
module sr_start_ctl #(
   parameter int DATA_W    = 8,
   parameter int T2_W      = 8,
   parameter int RD_DLY    = 7,
   parameter int WR_DLY    = 6,
   parameter int T2_EXTRA  = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [T2_W-1:0]   t2_lo_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              sdin_i,
   output logic              sclk_o,
   output logic              sdout_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o
);
   localparam int CNT_W = T2_W + 2;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (RD_DLY < 2 || WR_DLY < 2 || T2_EXTRA < 2) begin : g_bad_delay
         $error("start delays must be at least 2");
      end
      if (RD_DLY >= (1 << CNT_W) || WR_DLY >= (1 << CNT_W)) begin : g_bad_range
         $error("start delays exceed counter range");
      end
   endgenerate

   logic             arm, active, shift_out, fire, pending;
   logic [CNT_W-1:0] load_val, half_val;

   sr_mode_decode #(
      .T2_W(T2_W), .CNT_W(CNT_W), .RD_DLY(RD_DLY),
      .WR_DLY(WR_DLY), .T2_EXTRA(T2_EXTRA)
   ) decode_i (
      .mode_i(mode_i), .t2_lo_i(t2_lo_i), .rd_i(rd_i), .wr_i(wr_i),
      .arm_o(arm), .active_o(active), .shift_out_o(shift_out),
      .load_o(load_val), .half_o(half_val)
   );

   sr_start_delay #(.CNT_W(CNT_W)) delay_i (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .abort_i(!active),
      .load_i(load_val), .fire_o(fire), .pending_o(pending)
   );

   sr_shift_engine #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .MSB_FIRST(MSB_FIRST)
   ) engine_i (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .restart_i(arm),
      .abort_i(!active), .half_i(half_val), .shift_out_i(shift_out),
      .sdin_i(sdin_i), .wr_load_i(wr_i), .wr_data_i(wdata_i),
      .acc_i(rd_i || wr_i), .sclk_o(sclk_o), .sdout_o(sdout_o),
      .sr_o(rdata_o), .done_o(done_o)
   );

   assert_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (sclk_o && !pending));
   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i || wr_i) |=> !done_o);
endmodule

// File: tb/sr_start_ctl_tb.sv
module sr_start_ctl_tb_top;
   localparam int CLK_P = 10;
   localparam logic [2:0] M_OFF = 3'b000, M_IN_T2 = 3'b001, M_IN_SYS = 3'b010,
                          M_RSV = 3'b011, M_OUT_FREE = 3'b100,
                          M_OUT_T2 = 3'b101, M_OUT_SYS = 3'b110;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [2:0] mode = M_OFF;
   logic [7:0] t2lo = 8'd0, wdata = 8'd0;
   logic       rd = 1'b0, wr = 1'b0, sdin = 1'b0;
   logic       sclk, sdout, done;
   logic [7:0] rdata;

   int checks = 0, errors = 0, cyc = 0;
   int q_fall[$], q_done[$];
   bit q_bit[$];
   bit in_run = 0, chk_out = 0;
   logic [7:0] in_pat = 8'h00;
   int in_idx = 0;
   logic prev_sclk = 1'b1, prev_done = 1'b0;

   sr_start_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .t2_lo_i(t2lo),
      .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .sdin_i(sdin),
      .sclk_o(sclk), .sdout_o(sdout), .rdata_o(rdata), .done_o(done)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_sclk && !sclk) begin
            if (!in_run) begin
               check(q_fall.size() > 0, "R2/R3/R4/R5/R6 unexpected start", cyc, -1);
               if (q_fall.size() > 0) begin
                  int e;
                  e = q_fall.pop_front();
                  check(cyc == e, "R2/R3/R4/R5/R6 first fall", cyc, e);
               end
               in_run = 1;
            end
            if (!chk_out && in_idx < 8) sdin = in_pat[7 - in_idx];
         end
         if (!prev_sclk && sclk && in_run) begin
            if (chk_out && q_bit.size() > 0) begin
               bit b;
               b = q_bit.pop_front();
               check(sdout == b, "R8 serial bit", sdout, b);
            end
            in_idx++;
         end
         if (!prev_done && done) begin
            check(q_done.size() > 0, "R10 unexpected done", cyc, -1);
            if (q_done.size() > 0) begin
               int e;
               e = q_done.pop_front();
               check(cyc == e, "R7/R10 done time", cyc, e);
               check(sclk == 1'b1, "R10 clock high at done", sclk, 1);
            end
            in_run = 0;
         end
      end
      prev_sclk = sclk;
      prev_done = done;
   end

   // driver: one access, pushes expected first fall and done cycles
   task automatic access(input bit is_wr, input logic [7:0] d, input int dly,
                         input int half, input bit expect_start, input bit out_dir,
                         input logic [7:0] pat);
      @(negedge clk);
      if (is_wr) begin wr = 1'b1; wdata = d; end else rd = 1'b1;
      @(posedge clk);
      #1;
      q_fall.delete(); q_done.delete(); q_bit.delete();
      in_run = 0; in_idx = 0; chk_out = out_dir; in_pat = pat;
      if (expect_start) begin
         q_fall.push_back(cyc + dly);
         q_done.push_back(cyc + dly + 15 * half);
         if (out_dir) for (int i = 7; i >= 0; i--) q_bit.push_back(d[i]);
      end
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000 && (q_done.size() > 0 || q_fall.size() > 0); i++)
         @(negedge clk);
      check(q_done.size() == 0 && q_fall.size() == 0, "R7 transfer completes",
            q_done.size(), 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(sclk == 1'b1 && sdout == 1'b1, "R1 reset lines", {sclk, sdout}, 3);
      check(done == 1'b0 && rdata == 8'h00, "R1 reset state", rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 + R8: system clock shift-out on write
      mode = M_OUT_SYS;
      access(1, 8'hA5, 6, 1, 1, 1, 8'h00);
      wait_idle();
      check(done == 1'b1, "R10 flag set", done, 1);
      check(rdata == 8'hA5, "R8 register restored", rdata, 8'hA5);

      // R2 + R10: read clears flag and restarts
      access(0, 8'hA5, 7, 1, 1, 1, 8'h00);
      check(done == 1'b0, "R10 read clears flag", done, 0);
      wait_idle();

      // R9: system clock shift-in
      mode = M_IN_SYS;
      access(1, 8'h00, 6, 1, 1, 0, 8'h3C);
      check(done == 1'b0, "R10 write clears flag", done, 0);
      wait_idle();
      check(rdata == 8'h3C, "R9 shifted-in byte", rdata, 8'h3C);

      // R4 + R7: timer-paced shift-out
      mode = M_OUT_T2; t2lo = 8'd3;
      access(1, 8'h81, 5, 5, 1, 1, 8'h00);
      wait_idle();
      check(rdata == 8'h81, "R8 register restored timer mode", rdata, 8'h81);

      // R4 + R9: timer-paced shift-in started by a read
      mode = M_IN_T2; t2lo = 8'd1;
      access(0, 8'h00, 3, 3, 1, 0, 8'hC6);
      wait_idle();
      check(rdata == 8'hC6, "R9 timer shift-in byte", rdata, 8'hC6);

      // R5: free-running out, read arms nothing
      mode = M_OUT_FREE; t2lo = 8'd2;
      access(0, 8'h00, 4, 4, 0, 1, 8'h00);
      check(done == 1'b0, "R10 read clears flag free mode", done, 0);
      repeat (60) @(negedge clk);
      check(sclk == 1'b1 && !in_run, "R5 read does not start", sclk, 1);
      access(1, 8'h5A, 4, 4, 1, 1, 8'h00);
      wait_idle();

      // R6: retrigger while pending
      mode = M_OUT_SYS;
      access(1, 8'hF0, 6, 1, 1, 1, 8'h00);
      repeat (2) @(negedge clk);
      access(1, 8'h0F, 6, 1, 1, 1, 8'h00);
      wait_idle();
      check(rdata == 8'h0F, "R6 second write wins", rdata, 8'h0F);

      // R11: disabled and reserved codes
      mode = M_OFF;
      access(1, 8'h77, 6, 1, 0, 1, 8'h00);
      repeat (30) @(negedge clk);
      check(sclk == 1'b1 && !in_run, "R11 off mode idle", sclk, 1);
      check(rdata == 8'h77, "R11 write loads register", rdata, 8'h77);
      mode = M_RSV;
      access(1, 8'h12, 6, 1, 0, 1, 8'h00);
      repeat (30) @(negedge clk);
      check(sclk == 1'b1 && rdata == 8'h12, "R11 reserved code idle", rdata, 8'h12);

      // R11: cancel a pending start
      mode = M_OUT_SYS;
      access(1, 8'h33, 6, 1, 0, 1, 8'h00);
      mode = M_OFF;
      repeat (3) @(negedge clk);
      mode = M_OUT_SYS;
      repeat (30) @(negedge clk);
      check(sclk == 1'b1 && !in_run, "R11 pending start cancelled", sclk, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule